// File: doc/BRIEF.md
# Circular-Buffer FIR Tap Engine

This block is a sequential finite impulse response filter that spends one clock per tap. Each accepted 16-bit sample goes into a delay line held as a circular buffer. A write pointer wraps modulo the buffer depth, so stored samples never move. After it accepts a sample, the engine steps through the taps. On each cycle it reads one sample and one coefficient, forms their signed product and adds it into a 40-bit accumulator that saturates at its limits. After the last tap it presents the filtered value and pulses a completion strobe.

Samples arrive on a valid/ready stream. A sample transfers on a rising edge where `s_valid` and `s_ready` are both high. The engine drops `s_ready` for as long as taps are in progress, which is the only back-pressure it applies. A producer may hold `s_valid` and change `s_data` while `s_ready` is low; those values are never captured. A plain indexed write port loads the coefficients. The result is a held register qualified by a one-cycle strobe, with no back-pressure on the output side. With its reset coefficients the engine computes y(n) = 2·x(n) + 3·x(n−1) + 4·x(n−2) + 5·x(n−3).

Top module: `fir_tap_engine`

## Requirements
- R1: After reset, `s_ready` is 1, `y_done` is 0 and `y_data` is 0. Every delay-line entry is 0. Coefficient entry k (k = 0..NTAPS-1) holds k+2.
- R2: A sample is captured on a rising edge where `s_valid` and `s_ready` are both high. `s_ready` is low from the cycle after that edge until the cycle in which `y_done` is high. `s_data` presented while `s_ready` is low is ignored.
- R3: `y_done` is high for exactly one cycle: the cycle after the NTAPS-th rising edge that follows the capture edge. `s_ready` is high again in that same cycle.
- R4: The result is the sum over k of coef[k]·x(n−k), where x(n) is the sample just captured and k = 0 is the newest. With the reset coefficients this is 2·x(n)+3·x(n−1)+4·x(n−2)+5·x(n−3).
- R5: The delay line holds the last NTAPS captured samples in a circular buffer. A sample stays in use across NTAPS consecutive outputs and then drops out.
- R6: Samples and coefficients are signed two's-complement 16-bit values. Each product is the full signed 32-bit result.
- R7: When `coef_we` is high on a rising edge, `coef_data` is written to coefficient entry `coef_idx`. Entry `coef_idx` multiplies the sample `coef_idx` positions older than the newest. The write applies to every sample captured afterwards.
- R8: The accumulator is ACC_W bits and signed (40 by default). It is cleared when a sample is captured. Each tap's addition clamps to [−2^(ACC_W−1), 2^(ACC_W−1)−1] rather than wrapping, and the taps are added in order from k = 0 upward.
- R9: `y_data` keeps its value in every cycle in which `y_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Engine idle and able to take a sample |
| s_data | input | 16 | Signed input sample |
| coef_we | input | 1 | Coefficient write enable |
| coef_idx | input | $clog2(NTAPS) | Coefficient entry to write (tap age) |
| coef_data | input | 16 | Signed coefficient value |
| y_data | output | ACC_W | Saturated filter result, held |
| y_done | output | 1 | One-cycle strobe: new result on `y_data` |

## Verification
The bench feeds an impulse and then a long stream in which `s_valid` stays high and `s_data` changes every cycle. A design that captured data while busy, or that read the circular buffer from the wrong end, would then produce results that do not match the arithmetic model. A single-entry coefficient vector catches a reversed tap order or an off-by-one modulo pointer, because the output would show the wrong delayed sample. A 32-bit-accumulator instance driven with full-scale operands separates per-tap saturation from both wrap-around and a single clamp of the final sum: one case rises past the ceiling and then comes back down, and only per-tap clamping gives the expected value. The bench also counts cycles between capture and strobe, which exposes an extra or missing tap.

// File: rtl/fir_pkg.sv
package fir_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } fir_state_e;
endpackage

// File: rtl/fir_coef_bank.sv
module fir_coef_bank #(
  parameter int NTAPS  = 4,
  parameter int COEF_W = 16,
  localparam int IDX_W = $clog2(NTAPS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic signed [COEF_W-1:0] wr_val,
  input  logic [IDX_W-1:0]         rd_idx,
  output logic signed [COEF_W-1:0] rd_val
);
  logic signed [COEF_W-1:0] bank [NTAPS];

  for (genvar i = 0; i < NTAPS; i++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bank[i] <= COEF_W'(i + 2);
      else if (wr_en && (wr_idx == IDX_W'(i)))
        bank[i] <= wr_val;
    end
  end

  assign rd_val = bank[rd_idx];
endmodule

// File: rtl/fir_delay_line.sv
module fir_delay_line #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic signed [DATA_W-1:0] push_val,
  input  logic [IDX_W-1:0]         age,
  output logic signed [DATA_W-1:0] age_val
);
  logic signed [DATA_W-1:0] ring [DEPTH];
  logic [IDX_W-1:0]         wr_ptr;
  logic [IDX_W-1:0]         rd_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      wr_ptr <= '0;
    else if (push)
      wr_ptr <= wr_ptr + IDX_W'(1);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ring[i] <= '0;
      else if (push && (wr_ptr == IDX_W'(i)))
        ring[i] <= push_val;
    end
  end

  // newest entry sits one behind the write pointer; modulo by width
  assign rd_ptr  = wr_ptr - IDX_W'(1) - age;
  assign age_val = ring[rd_ptr];
endmodule

// File: rtl/fir_mac.sv
module fir_mac #(
  parameter int SAMP_W = 16,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 40,
  localparam int PROD_W = SAMP_W + COEF_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     step,
  input  logic signed [SAMP_W-1:0] samp,
  input  logic signed [COEF_W-1:0] coef,
  output logic signed [ACC_W-1:0]  acc_next
);
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W:0]    wide;
  logic signed [ACC_W-1:0]  acc_q;

  assign prod = samp * coef;
  assign wide = (ACC_W+1)'(acc_q) + (ACC_W+1)'(prod);

  always_comb begin
    if (wide[ACC_W] != wide[ACC_W-1])
      acc_next = wide[ACC_W] ? ACC_MIN : ACC_MAX;
    else
      acc_next = wide[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      acc_q <= '0;
    else if (clear)
      acc_q <= '0;
    else if (step)
      acc_q <= acc_next;
  end
endmodule

// File: rtl/fir_sequencer.sv
module fir_sequencer
  import fir_pkg::*;
#(
  parameter int NTAPS = 4,
  localparam int IDX_W = $clog2(NTAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             last,
  output logic [IDX_W-1:0] tap
);
  fir_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      tap   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_RUN;
          tap   <= '0;
        end
        ST_RUN: begin
          tap <= tap + IDX_W'(1);
          if (last) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state == ST_RUN);
  assign last = busy && (tap == IDX_W'(NTAPS - 1));
endmodule

// File: rtl/fir_tap_engine.sv
module fir_tap_engine #(
  parameter int NTAPS  = 4,
  parameter int SAMP_W = 16,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 40,
  localparam int IDX_W = $clog2(NTAPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [SAMP_W-1:0] s_data,
  input  logic              coef_we,
  input  logic [IDX_W-1:0]  coef_idx,
  input  logic [COEF_W-1:0] coef_data,
  output logic [ACC_W-1:0]  y_data,
  output logic              y_done
);
  logic                     accept;
  logic                     busy;
  logic                     last;
  logic [IDX_W-1:0]         tap;
  logic signed [SAMP_W-1:0] samp;
  logic signed [COEF_W-1:0] coef;
  logic signed [ACC_W-1:0]  acc_next;

  assign s_ready = !busy;
  assign accept  = s_valid && s_ready;

  fir_sequencer #(.NTAPS(NTAPS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept),
    .busy(busy), .last(last), .tap(tap)
  );

  fir_delay_line #(.DEPTH(NTAPS), .DATA_W(SAMP_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .push(accept), .push_val(s_data),
    .age(tap), .age_val(samp)
  );

  fir_coef_bank #(.NTAPS(NTAPS), .COEF_W(COEF_W)) u_coef (
    .clk(clk), .rst_n(rst_n), .wr_en(coef_we), .wr_idx(coef_idx),
    .wr_val(coef_data), .rd_idx(tap), .rd_val(coef)
  );

  fir_mac #(.SAMP_W(SAMP_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_mac (
    .clk(clk), .rst_n(rst_n), .clear(accept), .step(busy),
    .samp(samp), .coef(coef), .acc_next(acc_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_data <= '0;
      y_done <= 1'b0;
    end else begin
      y_done <= last;
      if (last) y_data <= acc_next;
    end
  end
endmodule

// File: rtl/fir_tap_engine_chk.sv
module fir_tap_engine_chk #(
  parameter int NTAPS = 4,
  parameter int ACC_W = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_valid,
  input logic             s_ready,
  input logic             y_done,
  input logic [ACC_W-1:0] y_data
);
  localparam int CW = $clog2(NTAPS + 2) + 1;
  logic [CW-1:0] since;

  // cycles elapsed since the capture edge, cleared by the strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      since <= '0;
    else if (s_valid && s_ready)
      since <= CW'(1);
    else if (y_done)
      since <= '0;
    else if (since != '0)
      since <= since + CW'(1);
  end

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    y_done |=> !y_done);

  // R3
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    y_done |-> (since == CW'(NTAPS + 1)));

  // R3
  ready_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    y_done |-> s_ready);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !y_done |-> $stable(y_data));
endmodule

bind fir_tap_engine fir_tap_engine_chk #(.NTAPS(NTAPS), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .y_done(y_done), .y_data(y_data)
);

// File: tb/tb_fir_tap_engine.sv
module tb_fir_tap_engine;
  localparam int NT = 4;
  localparam int AW0 = 40;
  localparam int AW1 = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [15:0] s_data = '0;
  logic [1:0]  coef_idx = '0;
  logic [15:0] coef_data = '0;
  logic        vld [2];
  logic        we  [2];
  logic        rdy [2];
  logic        done [2];
  logic [AW0-1:0] y0;
  logic [AW1-1:0] y1;

  fir_tap_engine dut (
    .clk(clk), .rst_n(rst_n), .s_valid(vld[0]), .s_ready(rdy[0]),
    .s_data(s_data), .coef_we(we[0]), .coef_idx(coef_idx),
    .coef_data(coef_data), .y_data(y0), .y_done(done[0])
  );

  fir_tap_engine #(.ACC_W(AW1)) dut_sat (
    .clk(clk), .rst_n(rst_n), .s_valid(vld[1]), .s_ready(rdy[1]),
    .s_data(s_data), .coef_we(we[1]), .coef_idx(coef_idx),
    .coef_data(coef_data), .y_data(y1), .y_done(done[1])
  );

  int checks = 0;
  int errors = 0;
  longint cm [2][NT];
  longint hist [2][NT];
  int hp [2];
  int unsigned lcg = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint yval(input int w);
    if (w == 0) return longint'($signed(y0));
    return longint'($signed(y1));
  endfunction

  function automatic longint model_accept(input int w, input longint x);
    longint acc = 0;
    longint hi = (w == 0) ? ((64'sd1 <<< (AW0 - 1)) - 1) : ((64'sd1 <<< (AW1 - 1)) - 1);
    longint lo = -hi - 1;
    hist[w][hp[w]] = x;
    hp[w] = (hp[w] + 1) % NT;
    for (int k = 0; k < NT; k++) begin
      acc = acc + cm[w][k] * hist[w][(hp[w] - 1 - k + 2 * NT) % NT];
      if (acc > hi) acc = hi;
      if (acc < lo) acc = lo;
    end
    return acc;
  endfunction

  function automatic longint next_val();
    int sel;
    lcg = lcg * 32'd1103515245 + 32'd12345;
    sel = int'(lcg[27:24]);
    case (sel)
      0: return -32768;
      1: return 32767;
      2: return -1;
      3: return 1;
      4: return 0;
      default: return longint'($signed(lcg[31:16]));
    endcase
  endfunction

  task automatic load_coef(input int w, input int idx, input longint v);
    @(negedge clk);
    coef_idx = 2'(idx);
    coef_data = 16'(v);
    we[w] = 1'b1;
    @(negedge clk);
    we[w] = 1'b0;
    cm[w][idx] = v;
  endtask

  // single sample: checks handshake, latency and value
  task automatic push_one(input int w, input longint x, input string req);
    longint e;
    int cnt = 0;
    @(negedge clk);
    chk(rdy[w] == 1'b1, "R2 idle ready", longint'(rdy[w]), 1);
    s_data = 16'(x);
    vld[w] = 1'b1;
    @(negedge clk);
    vld[w] = 1'b0;
    e = model_accept(w, x);
    chk(rdy[w] == 1'b0, "R2 busy ready low", longint'(rdy[w]), 0);
    while (!done[w] && cnt < 40) begin
      @(negedge clk);
      cnt++;
    end
    chk(cnt == NT, "R3 latency", cnt, NT);
    chk(rdy[w] == 1'b1, "R3 ready at done", longint'(rdy[w]), 1);
    chk(yval(w) == e, req, yval(w), e);
    @(negedge clk);
    chk(done[w] == 1'b0, "R3 single pulse", longint'(done[w]), 0);
    chk(yval(w) == e, "R9 held", yval(w), e);
  endtask

  // valid held high, data changing every cycle: only ready cycles capture
  task automatic stream(input int w, input int ncyc, input string req);
    longint pend = 0;
    bit has = 1'b0;
    longint x;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      if (done[w]) begin
        chk(has, "R3 unexpected done", 1, 0);
        chk(yval(w) == pend, req, yval(w), pend);
        has = 1'b0;
      end
      x = next_val();
      s_data = 16'(x);
      vld[w] = 1'b1;
      if (rdy[w]) begin
        pend = model_accept(w, x);
        has = 1'b1;
      end
    end
    @(negedge clk);
    vld[w] = 1'b0;
    if (done[w]) begin
      chk(yval(w) == pend, req, yval(w), pend);
      has = 1'b0;
    end
    for (int c = 0; c < NT + 2 && has; c++) begin
      @(negedge clk);
      if (done[w]) begin
        chk(yval(w) == pend, req, yval(w), pend);
        has = 1'b0;
      end
    end
    chk(!has, "R3 final done seen", longint'(has), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int w = 0; w < 2; w++) begin
      vld[w] = 1'b0;
      we[w] = 1'b0;
      hp[w] = 0;
      for (int k = 0; k < NT; k++) begin
        cm[w][k] = k + 2;
        hist[w][k] = 0;
      end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rdy[0] == 1'b1, "R1 ready", longint'(rdy[0]), 1);
    chk(done[0] == 1'b0, "R1 done", longint'(done[0]), 0);
    chk(y0 == '0, "R1 y_data", longint'(y0), 0);
    chk(rdy[1] == 1'b1 && done[1] == 1'b0 && y1 == '0, "R1 sat instance", longint'(y1), 0);

    // R4 R1 impulse against reset coefficients 2,3,4,5
    push_one(0, 1, "R4 impulse tap0");
    chk(yval(0) == 2, "R4 impulse literal", yval(0), 2);
    push_one(0, 0, "R4 impulse tap1");
    chk(yval(0) == 3, "R4 impulse literal", yval(0), 3);
    push_one(0, 0, "R4 impulse tap2");
    chk(yval(0) == 4, "R4 impulse literal", yval(0), 4);
    push_one(0, 0, "R4 impulse tap3");
    chk(yval(0) == 5, "R4 impulse literal", yval(0), 5);
    // R5 impulse has left the circular buffer
    push_one(0, 0, "R5 dropout");
    chk(yval(0) == 0, "R5 dropout literal", yval(0), 0);

    // R2 R4 R5 R6 streaming with default coefficients
    stream(0, 300, "R6 stream default");

    // R7 single-entry coefficient selects x(n-2)
    for (int k = 0; k < NT; k++) load_coef(0, k, (k == 2) ? 1 : 0);
    push_one(0, 10, "R7 unit tap");
    push_one(0, 20, "R7 unit tap");
    push_one(0, 30, "R7 unit tap");
    push_one(0, 40, "R7 unit tap");
    chk(yval(0) == 20, "R7 unit tap literal", yval(0), 20);

    // R6 R7 signed coefficient set
    load_coef(0, 0, -7);
    load_coef(0, 1, 32767);
    load_coef(0, 2, -32768);
    load_coef(0, 3, 1234);
    stream(0, 300, "R6 stream signed coefs");

    // R8 positive clamp on 32-bit accumulator
    for (int k = 0; k < NT; k++) load_coef(1, k, -32768);
    for (int i = 0; i < NT; i++) push_one(1, -32768, "R8 positive clamp");
    chk(yval(1) == 64'sd2147483647, "R8 positive clamp literal", yval(1), 64'sd2147483647);
    // R8 negative clamp
    for (int i = 0; i < NT; i++) push_one(1, 32767, "R8 negative clamp");
    chk(yval(1) == -64'sd2147483648, "R8 negative clamp literal", yval(1), -64'sd2147483648);
    // R8 per-tap clamp then descend
    load_coef(1, 3, 32767);
    for (int i = 0; i < NT; i++) push_one(1, -32768, "R8 per-tap clamp");
    chk(yval(1) == 64'sd1073774591, "R8 per-tap literal", yval(1), 64'sd1073774591);
    stream(1, 400, "R8 stream extremes");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule